// File: doc/BRIEF.md
# Direction-Batching Read/Write Bus Scheduler

This block merges two independent request streams onto one command stream for a memory bus that carries only one direction at a time. Write requests and read requests each arrive on their own valid/ready channel. The block issues at most one command per cycle, tagged with a direction flag. When the bus direction changes, it inserts a fixed dead time of `TURN_CYC` cycles, and no command of either direction goes out during that time.

Every direction change costs dead time, so the scheduler does not alternate fairly. It keeps serving the direction it is in while requests of that kind are waiting. If the other side is also waiting, it changes direction after `BATCH_MAX` back-to-back commands so that the other side is not starved. If only one side has work, that side runs with no limit. The block counts the turnarounds it takes and presents the count as an output. A bench can use it to confirm that batching keeps the number of switches low.

Top module: `rw_turn_sched`

## Requirements
- R1: In any cycle at most one of `wr_ready` and `rd_ready` is high. On the output, `cmd_is_wr` = 1 marks a write and 0 marks a read.
- R2: A request accepted on a rising edge (valid and ready both high) appears on the command output one cycle later, with `cmd_valid` high, its own address and its direction flag.
- R3: After reset, `cmd_valid` is low, `turn_count` is 0 and the bus faces the read direction. So a lone write presented right after reset comes out as a command exactly `TURN_CYC`+2 cycles after it is presented.
- R4: On a change of direction, the first command of the new direction comes out exactly `TURN_CYC`+2 cycles after the last command of the old direction. `cmd_valid` stays low for the `TURN_CYC`+1 cycles in between.
- R5: While only one channel has requests, its commands go out on consecutive cycles with no batch limit and no turnaround.
- R6: While both channels have requests, the scheduler changes direction after `BATCH_MAX` consecutive commands of the current direction.
- R7: When the current direction's channel runs empty while the other channel is waiting, the scheduler changes direction at once, even below the batch limit.
- R8: `turn_count` rises by exactly one for each direction change and never changes otherwise.
- R9: Commands of one direction leave in the order their requests were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write request present |
| wr_addr | input | ADDR_W | Write request address |
| wr_ready | output | 1 | Write request taken this cycle |
| rd_valid | input | 1 | Read request present |
| rd_addr | input | ADDR_W | Read request address |
| rd_ready | output | 1 | Read request taken this cycle |
| cmd_valid | output | 1 | Command issued on the bus |
| cmd_is_wr | output | 1 | Direction of the command, 1 = write |
| cmd_addr | output | ADDR_W | Address of the command |
| turn_count | output | CNT_W | Number of direction changes since reset |

## Verification
A handshake at one edge shows up on the command output after that edge. The monitor samples on falling edges, so each command carries the number of the clock edge that produced it. A direction change costs one decision cycle, then `TURN_CYC` countdown cycles, then the accepting edge. The bench therefore expects exactly `TURN_CYC`+2 edges between the last old-direction command and the first new-direction command, and exactly one edge between same-direction commands; it compares recorded edge numbers rather than waiting loosely. The first write after reset is timed from the falling edge at which it is presented, and `turn_count` is compared after each scenario has fully drained.

// File: rtl/rw_sched_pkg.sv
package rw_sched_pkg;
  typedef enum logic {
    DIR_RD = 1'b0,
    DIR_WR = 1'b1
  } bus_dir_e;
endpackage

// File: rtl/rw_dir_ctrl.sv
// Direction state, turnaround countdown and batch length tracking.
module rw_dir_ctrl
  import rw_sched_pkg::*;
#(
  parameter int TURN_CYC  = 3,
  parameter int BATCH_MAX = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_pend,
  input  logic     rd_pend,
  output bus_dir_e dir,
  output logic     issue_wr,
  output logic     issue_rd,
  output logic     turn_evt
);
  localparam int TW = $clog2(TURN_CYC + 1);
  localparam int BW = $clog2(BATCH_MAX + 1);

  bus_dir_e       dir_q, dir_d;
  logic [TW-1:0]  turn_q, turn_d;
  logic [BW-1:0]  batch_q, batch_d;
  logic           cur_pend, oth_pend, quiet, under, issue, flip, st_en;

  always_comb begin
    cur_pend = (dir_q == DIR_WR) ? wr_pend : rd_pend;
    oth_pend = (dir_q == DIR_WR) ? rd_pend : wr_pend;
    quiet    = (turn_q != '0);
    under    = (batch_q < BW'(BATCH_MAX));
    issue    = !quiet && cur_pend && (under || !oth_pend);
    flip     = !quiet && oth_pend && !issue;

    dir_d   = flip ? bus_dir_e'(~dir_q) : dir_q;
    turn_d  = flip ? TW'(TURN_CYC) : (quiet ? turn_q - TW'(1) : turn_q);
    if (flip)          batch_d = '0;
    else if (issue)    batch_d = under ? batch_q + BW'(1) : batch_q;
    else if (!cur_pend) batch_d = '0;
    else               batch_d = batch_q;

    st_en = flip || issue || quiet || (batch_q != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= DIR_RD;
      turn_q  <= '0;
      batch_q <= '0;
    end else if (st_en) begin
      dir_q   <= dir_d;
      turn_q  <= turn_d;
      batch_q <= batch_d;
    end
  end

  assign dir      = dir_q;
  assign issue_wr = issue && (dir_q == DIR_WR);
  assign issue_rd = issue && (dir_q == DIR_RD);
  assign turn_evt = flip;
endmodule

// File: rtl/rw_cmd_out.sv
// Registered command output and turnaround counter.
module rw_cmd_out #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_wr,
  input  logic              issue_rd,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              turn_evt,
  output logic              cmd_valid,
  output logic              cmd_is_wr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CNT_W-1:0]  turn_count
);
  logic              vld_q, vld_d;
  logic              wr_q, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pay_en;

  always_comb begin
    vld_d  = issue_wr || issue_rd;
    pay_en = vld_d;
    wr_d   = issue_wr;
    addr_d = issue_wr ? wr_addr : rd_addr;
    cnt_d  = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      vld_q <= vld_d;
      if (pay_en) begin
        wr_q   <= wr_d;
        addr_q <= addr_d;
      end
      if (turn_evt) cnt_q <= cnt_d;
    end
  end

  assign cmd_valid  = vld_q;
  assign cmd_is_wr  = wr_q;
  assign cmd_addr   = addr_q;
  assign turn_count = cnt_q;
endmodule

// File: rtl/rw_turn_sched.sv
module rw_turn_sched
  import rw_sched_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 16,
  parameter int TURN_CYC  = 3,
  parameter int BATCH_MAX = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              wr_ready,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ready,
  output logic              cmd_valid,
  output logic              cmd_is_wr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [CNT_W-1:0]  turn_count
);
  bus_dir_e dir;
  logic     issue_wr, issue_rd, turn_evt;

  rw_dir_ctrl #(.TURN_CYC(TURN_CYC), .BATCH_MAX(BATCH_MAX)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_pend(wr_valid), .rd_pend(rd_valid),
    .dir(dir), .issue_wr(issue_wr), .issue_rd(issue_rd), .turn_evt(turn_evt)
  );

  rw_cmd_out #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .issue_wr(issue_wr), .issue_rd(issue_rd),
    .wr_addr(wr_addr), .rd_addr(rd_addr), .turn_evt(turn_evt),
    .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr), .cmd_addr(cmd_addr),
    .turn_count(turn_count)
  );

  assign wr_ready = issue_wr;
  assign rd_ready = issue_rd;
endmodule

// File: rtl/rw_turn_sched_chk.sv
module rw_turn_sched_chk #(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int TURN_CYC = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_ready,
  input logic              cmd_valid,
  input logic              cmd_is_wr,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [CNT_W-1:0]  turn_count
);
  localparam int GW  = $clog2(TURN_CYC + 2) + 1;
  localparam int LIM = TURN_CYC + 1;

  logic [GW-1:0] gap_q;
  logic          last_wr_q;

  // Idle-cycle counter since the last command, saturating at LIM.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q     <= '0;
      last_wr_q <= 1'b0;
    end else if (cmd_valid) begin
      gap_q     <= '0;
      last_wr_q <= cmd_is_wr;
    end else if (gap_q < GW'(LIM)) begin
      gap_q <= gap_q + GW'(1);
    end
  end

  a_r1_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ready && rd_ready));

  a_r2_wr_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (cmd_valid && cmd_is_wr && cmd_addr == $past(wr_addr)));

  a_r2_rd_echo: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> (cmd_valid && !cmd_is_wr && cmd_addr == $past(rd_addr)));

  a_r4_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && (cmd_is_wr != last_wr_q)) |-> (gap_q >= GW'(LIM)));

  a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_count == $past(turn_count)) || (turn_count == $past(turn_count) + CNT_W'(1)));
endmodule

bind rw_turn_sched rw_turn_sched_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TURN_CYC(TURN_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_addr(rd_addr),
  .rd_ready(rd_ready), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
  .cmd_addr(cmd_addr), .turn_count(turn_count)
);

// File: tb/rw_turn_sched_bench.sv
module rw_turn_sched_bench;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int T  = 3;
  localparam int B  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid, rd_valid, wr_ready, rd_ready;
  logic [AW-1:0] wr_addr, rd_addr, cmd_addr;
  logic cmd_valid, cmd_is_wr;
  logic [CW-1:0] turn_count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [AW-1:0] wq [64];
  logic [AW-1:0] rq [64];
  int wn = 0, wi = 0, rn = 0, ri = 0;

  logic          ldir  [256];
  logic [AW-1:0] laddr [256];
  int            lcyc  [256];
  int            ln = 0;

  always #10 clk = ~clk;

  rw_turn_sched #(.ADDR_W(AW), .CNT_W(CW), .TURN_CYC(T), .BATCH_MAX(B)) u_rw_turn_sched (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .cmd_valid(cmd_valid), .cmd_is_wr(cmd_is_wr),
    .cmd_addr(cmd_addr), .turn_count(turn_count)
  );

  assign wr_valid = (wi < wn);
  assign rd_valid = (ri < rn);
  assign wr_addr  = wq[wi % 64];
  assign rd_addr  = rq[ri % 64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wr_valid && wr_ready) wi <= wi + 1;
    if (rd_valid && rd_ready) ri <= ri + 1;
  end

  always @(negedge clk) begin
    if (rst_n && cmd_valid && ln < 256) begin
      ldir[ln]  <= cmd_is_wr;
      laddr[ln] <= cmd_addr;
      lcyc[ln]  <= cyc;
      ln        <= ln + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_wr(input logic [AW-1:0] a);
    wq[wn % 64] = a;
    wn++;
  endtask

  task automatic push_rd(input logic [AW-1:0] a);
    rq[rn % 64] = a;
    rn++;
  endtask

  task automatic drain();
    while (wi != wn || ri != rn) @(negedge clk);
    repeat (T + 6) @(negedge clk);
  endtask

  // Compare a log stretch against expected directions/addresses and spacing.
  task automatic check_seq(input int base, input int n, input logic ed [16],
                           input logic [AW-1:0] ea [16], input string req);
    chk(ln - base == n, {req, " command count"}, ln - base, n);
    for (int k = 0; k < n && k < 16; k++) begin
      chk(ldir[base + k] == ed[k], {req, " R1 direction"}, ldir[base + k], ed[k]);
      chk(laddr[base + k] == ea[k], {req, " R9 order/R2 address"}, laddr[base + k], ea[k]);
      if (k > 0) begin
        if (ed[k] != ed[k - 1])
          chk(lcyc[base + k] - lcyc[base + k - 1] == T + 2, "R4 turnaround spacing",
              lcyc[base + k] - lcyc[base + k - 1], T + 2);
        else
          chk(lcyc[base + k] - lcyc[base + k - 1] == 1, "R5 back-to-back spacing",
              lcyc[base + k] - lcyc[base + k - 1], 1);
      end
    end
  endtask

  // R3: reset state and first write timing.
  task automatic t_reset_first_write();
    int c0, base;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(cmd_valid == 1'b0, "R3 cmd_valid in reset", cmd_valid, 0);
    chk(turn_count == '0, "R3 turn_count in reset", turn_count, 0);
    rst_n = 1'b1;
    chk(wr_ready == 1'b0 && rd_ready == 1'b0, "R1 no ready when idle", wr_ready, 0);
    base = ln;
    c0 = cyc;
    push_wr(16'hA000);
    drain();
    chk(ln - base == 1, "R3 one write issued", ln - base, 1);
    chk(lcyc[base] == c0 + T + 2, "R3 first write delay", lcyc[base] - c0, T + 2);
    chk(ldir[base] == 1'b1 && laddr[base] == 16'hA000, "R2 write echo", laddr[base], 16'hA000);
    chk(turn_count == CW'(1), "R8 first turnaround counted", turn_count, 1);
  endtask

  // R5: single channel runs without limit; one switch to get there.
  task automatic t_reads_only();
    int base;
    logic ed [16];
    logic [AW-1:0] ea [16];
    base = ln;
    for (int k = 0; k < 6; k++) begin
      push_rd(AW'(16'h5000 + k));
      ed[k] = 1'b0;
      ea[k] = AW'(16'h5000 + k);
    end
    drain();
    check_seq(base, 6, ed, ea, "R5 reads only");
    chk(turn_count == CW'(2), "R8 reads-only switch count", turn_count, 2);
  endtask

  // R6/R7: both channels loaded, starting in read direction.
  task automatic t_mixed();
    int base;
    logic ed [16];
    logic [AW-1:0] ea [16];
    base = ln;
    for (int k = 0; k < 6; k++) begin
      push_wr(AW'(16'hB000 + k));
      push_rd(AW'(16'h6000 + k));
    end
    for (int k = 0; k < 4; k++) begin
      ed[k] = 1'b0;      ea[k] = AW'(16'h6000 + k);
      ed[k + 4] = 1'b1;  ea[k + 4] = AW'(16'hB000 + k);
    end
    ed[8] = 1'b0;  ea[8] = 16'h6004;
    ed[9] = 1'b0;  ea[9] = 16'h6005;
    ed[10] = 1'b1; ea[10] = 16'hB004;
    ed[11] = 1'b1; ea[11] = 16'hB005;
    drain();
    check_seq(base, 12, ed, ea, "R6 batch limit");
    chk(turn_count == CW'(5), "R8 mixed switch count", turn_count, 5);
  endtask

  // R7: the other side runs dry below the limit, then switch back.
  task automatic t_short_other();
    int base;
    logic ed [16];
    logic [AW-1:0] ea [16];
    base = ln;
    for (int k = 0; k < 8; k++) push_wr(AW'(16'hC000 + k));
    push_rd(16'h7000);
    for (int k = 0; k < 4; k++) begin
      ed[k] = 1'b1; ea[k] = AW'(16'hC000 + k);
      ed[k + 5] = 1'b1; ea[k + 5] = AW'(16'hC004 + k);
    end
    ed[4] = 1'b0; ea[4] = 16'h7000;
    drain();
    check_seq(base, 9, ed, ea, "R7 early switch");
    chk(turn_count == CW'(7), "R8 short-other switch count", turn_count, 7);
  endtask

  // R5: write only while already in write direction: no turnaround.
  task automatic t_writes_stay();
    int base;
    logic ed [16];
    logic [AW-1:0] ea [16];
    base = ln;
    for (int k = 0; k < 7; k++) begin
      push_wr(AW'(16'hD000 + k));
      ed[k] = 1'b1;
      ea[k] = AW'(16'hD000 + k);
    end
    drain();
    check_seq(base, 7, ed, ea, "R5 writes stay");
    chk(turn_count == CW'(7), "R8 no extra switch", turn_count, 7);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_first_write();
    t_reads_only();
    t_mixed();
    t_short_other();
    t_writes_stay();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule